// File: doc/BRIEF.md
# Interrupt Request and Acknowledge Core

This block collects eight interrupt request lines, keeps a request register, a mask register and an in-service register, and signals a host processor through a single interrupt output. The processor answers with two low pulses on an active-low acknowledge strobe. The first pulse claims the winning request and moves it into service. The second pulse reads an 8-bit vector. The vector's upper five bits come from a programmed base and its lower three bits carry the level number.

Priority is fixed, and level 0 is the most urgent. A request can interrupt only when it is unmasked and more urgent than every level already in service. In-service bits are cleared in one of two ways. The first is an end-of-interrupt command, which can name a level or clear the most urgent level in service. The second is automatic clearing when the second pulse ends. The acknowledge strobe is sampled in the block clock domain, and its falling and rising edges drive a four-state sequencer.

Top module: `irq_ack_core`

## Requirements
- R1: A request with its mask bit at 1 never raises `int_out` and is never claimed by an acknowledge. A masked level never blocks a less urgent unmasked level.
- R2: With `level_mode`=0, a 0-to-1 transition on a line sets its request bit, and the bit stays set after the line drops until an acknowledge claims it. With `level_mode`=1, the request bit follows the line one clock later.
- R3: From the clock after the first acknowledge falling edge until the clock after the second pulse's rising edge, the request register holds its value. An edge that arrives on a line in that window is never latched.
- R4: The first falling edge of `ack_n` sets the in-service bit of the winning level, clears its request bit and drops `int_out`, all one clock later.
- R5: From the clock after the second falling edge until the clock after the following rising edge, `vec_oe` is 1 and `vec_out` = {`vec_base`, level[2:0]}. At all other times `vec_oe` is 0 and `vec_out` is 0.
- R6: With `auto_eoi`=1, the in-service bit claimed by the sequence clears one clock after the rising edge that ends the second pulse. With `auto_eoi`=0, it stays set.
- R7: When `eoi_req`=1 and `eoi_specific`=1, the bit `eoi_lvl` of the in-service register clears. When `eoi_req`=1 and `eoi_specific`=0, only the lowest-numbered set bit clears. Either way the clear takes effect one clock later.
- R8: `int_out` is 1 exactly when some unmasked request has a lower level number than every set in-service bit and no acknowledge sequence is running.
- R9: If no request qualifies at the first falling edge, the vector low bits read 111 and the in-service register is left unchanged.
- R10: During reset the request and in-service registers read 0, the mask register reads all ones, and `int_out` and `vec_oe` read 0.
- R11: The mask status output `imr_stat` takes the value of `mask_in` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Interrupt request lines, bit n is level n |
| ack_n | input | 1 | Active-low acknowledge strobe, two pulses per sequence |
| mask_in | input | 8 | Mask byte, 1 blocks the level |
| level_mode | input | 1 | 0 edge-latched requests, 1 level-sampled requests |
| auto_eoi | input | 1 | 1 clears the claimed in-service bit at the end of the second pulse |
| vec_base | input | 5 | Upper bits of the vector |
| eoi_req | input | 1 | End-of-interrupt command strobe, one clock |
| eoi_specific | input | 1 | 1 clears level `eoi_lvl`, 0 clears the most urgent in-service level |
| eoi_lvl | input | 3 | Level for a specific end-of-interrupt |
| int_out | output | 1 | Interrupt toward the processor |
| vec_out | output | 8 | Vector byte, 0 when not driven |
| vec_oe | output | 1 | Vector drive enable |
| irr_stat | output | 8 | Request register contents |
| isr_stat | output | 8 | In-service register contents |
| imr_stat | output | 8 | Mask register contents |

## Verification
The hardest case to reach is a new edge that arrives while the request register is frozen in the middle of an acknowledge sequence. If it is handled wrongly, the request shows up as a phantom pending level only after the sequence has ended. The stimulus raises a more urgent line between the two acknowledge pulses and holds it high afterwards. The bench then checks that the request register stays clear, because no new edge follows. Nested service is reached by leaving a level in service without an end-of-interrupt. The bench then raises a less urgent request and a more urgent request in turn, and checks the interrupt output after each.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    ACK_IDLE   = 2'd0,
    ACK_FIRST  = 2'd1,
    ACK_GAP    = 2'd2,
    ACK_SECOND = 2'd3
  } ack_state_e;

  localparam int unsigned MAXN = 32;

  // Index of the lowest set bit among the first n bits; n-1 when none is set.
  function automatic int unsigned pick_level(input logic [MAXN-1:0] v, input int unsigned n);
    int unsigned r;
    r = n - 1;
    for (int i = int'(n) - 1; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // Bit i set when level i is more urgent than every in-service level.
  function automatic logic [MAXN-1:0] outrank_mask(input logic [MAXN-1:0] isr, input int unsigned n);
    logic [MAXN-1:0] m;
    logic blocked;
    m = '0;
    blocked = 1'b0;
    for (int i = 0; i < int'(n); i++) begin
      if (isr[i]) blocked = 1'b1;
      m[i] = ~blocked;
    end
    return m;
  endfunction

  // Keeps only the lowest set bit.
  function automatic logic [MAXN-1:0] lowest_onehot(input logic [MAXN-1:0] v);
    return v & (~v + 1'b1);
  endfunction

endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_in,
  input  logic          level_mode,
  input  logic          freeze,
  input  logic          clr_en,
  input  logic [LW-1:0] clr_idx,
  output logic [N-1:0]  irr
);

  logic [N-1:0] irq_prev;
  logic [N-1:0] irr_q;
  logic [N-1:0] irr_d;

  // One next-state slice per request line.
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic edge_seen;
    logic hit_clr;
    assign edge_seen = irq_in[g] & ~irq_prev[g];
    assign hit_clr   = clr_en && (clr_idx == LW'(g));
    always_comb begin
      if (freeze) begin
        irr_d[g] = irr_q[g];
      end else if (hit_clr) begin
        irr_d[g] = 1'b0;
      end else if (level_mode) begin
        irr_d[g] = irq_in[g];
      end else begin
        irr_d[g] = irr_q[g] | edge_seen;
      end
    end
  end

  // Line history keeps tracking while frozen, so edges inside the window are lost.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_prev <= '0;
      irr_q    <= '0;
    end else begin
      irq_prev <= irq_in;
      irr_q    <= irr_d;
    end
  end

  assign irr = irr_q;

  AST_IRR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(irr_q)); // R3

  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && level_mode && !clr_en) |=> (irr_q == $past(irq_in))); // R2

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irr,
  input  logic [N-1:0]  imr,
  input  logic [N-1:0]  isr,
  output logic          req_any,
  output logic [LW-1:0] req_lvl
);

  logic [irq_pkg::MAXN-1:0] live_w;
  logic [irq_pkg::MAXN-1:0] isr_w;
  logic [irq_pkg::MAXN-1:0] gate_w;

  always_comb begin
    live_w = '0;
    isr_w  = '0;
    live_w[N-1:0] = irr & ~imr;
    isr_w[N-1:0]  = isr;
  end

  assign gate_w  = live_w & irq_pkg::outrank_mask(isr_w, N);
  assign req_any = |gate_w;
  assign req_lvl = LW'(irq_pkg::pick_level(gate_w, N));

  AST_PICK_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    req_any |-> (irr[req_lvl] && !imr[req_lvl])); // R1

  AST_PICK_OUTRANKS: assert property (@(posedge clk) disable iff (!rst_n)
    req_any |-> ((isr & ((N'(1) << req_lvl) | ((N'(1) << req_lvl) - N'(1)))) == '0)); // R8

endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq #(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = 3,
  parameter int unsigned VW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_n,
  input  logic             req_any,
  input  logic [LW-1:0]    req_lvl,
  input  logic             auto_eoi,
  input  logic             eoi_req,
  input  logic             eoi_specific,
  input  logic [LW-1:0]    eoi_lvl,
  input  logic [VW-LW-1:0] vec_base,
  output logic             in_ack,
  output logic             clr_en,
  output logic [LW-1:0]    clr_idx,
  output logic             ev_first,
  output logic [N-1:0]     isr,
  output logic [VW-1:0]    vec_out,
  output logic             vec_oe
);

  import irq_pkg::*;

  ack_state_e st_q, st_d;
  logic          ack_q;
  logic          fall_w, rise_w;
  logic          ev_second, ev_end;
  logic [LW-1:0] lvl_q;
  logic          spur_q;
  logic [N-1:0]  isr_q, isr_d, set_v, aeoi_v, eoi_v;
  logic [VW-1:0] vec_q;
  logic          oe_q;
  logic [MAXN-1:0] isr_w;

  assign fall_w    = ack_q & ~ack_n;
  assign rise_w    = ~ack_q & ack_n;
  assign ev_first  = (st_q == ACK_IDLE)   && fall_w;
  assign ev_second = (st_q == ACK_GAP)    && fall_w;
  assign ev_end    = (st_q == ACK_SECOND) && rise_w;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ACK_IDLE:   if (fall_w) st_d = ACK_FIRST;
      ACK_FIRST:  if (rise_w) st_d = ACK_GAP;
      ACK_GAP:    if (fall_w) st_d = ACK_SECOND;
      ACK_SECOND: if (rise_w) st_d = ACK_IDLE;
      default:    st_d = ACK_IDLE;
    endcase
  end

  always_comb begin
    isr_w = '0;
    isr_w[N-1:0] = isr_q;
  end

  always_comb begin
    set_v  = (ev_first && req_any) ? (N'(1) << req_lvl) : '0;
    aeoi_v = (ev_end && auto_eoi && !spur_q) ? (N'(1) << lvl_q) : '0;
    if (!eoi_req)          eoi_v = '0;
    else if (eoi_specific) eoi_v = N'(1) << eoi_lvl;
    else                   eoi_v = N'(lowest_onehot(isr_w));
    isr_d = (isr_q | set_v) & ~aeoi_v & ~eoi_v;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q  <= 1'b1;
      st_q   <= ACK_IDLE;
      lvl_q  <= '0;
      spur_q <= 1'b0;
      isr_q  <= '0;
      vec_q  <= '0;
      oe_q   <= 1'b0;
    end else begin
      ack_q <= ack_n;
      st_q  <= st_d;
      isr_q <= isr_d;
      if (ev_first) begin
        lvl_q  <= req_any ? req_lvl : LW'(N - 1);
        spur_q <= ~req_any;
      end
      if (ev_second) begin
        vec_q <= {vec_base, lvl_q};
        oe_q  <= 1'b1;
      end else if (ev_end) begin
        oe_q  <= 1'b0;
      end
    end
  end

  assign in_ack  = (st_q != ACK_IDLE);
  assign clr_en  = ev_first && req_any;
  assign clr_idx = req_lvl;
  assign isr     = isr_q;
  assign vec_oe  = oe_q;
  assign vec_out = oe_q ? vec_q : '0;

  AST_ISR_SET_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_first && req_any) |=> isr_q[lvl_q]); // R4

  AST_VEC_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> (st_q == ACK_SECOND)); // R5

  AST_AEOI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_end && auto_eoi && !spur_q) |=> !isr_q[$past(lvl_q)]); // R6

  AST_SPUR_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_first && !req_any && !eoi_req) |=> $stable(isr_q)); // R9

  AST_SPUR_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_first && !req_any) |=> (lvl_q == LW'(N - 1))); // R9

endmodule

// File: rtl/irq_ack_core.sv
module irq_ack_core #(
  parameter  int unsigned NUM_IRQ = 8,
  parameter  int unsigned VEC_W   = 8,
  localparam int unsigned LVL_W   = $clog2(NUM_IRQ),
  localparam int unsigned BASE_W  = VEC_W - LVL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               ack_n,
  input  logic [NUM_IRQ-1:0] mask_in,
  input  logic               level_mode,
  input  logic               auto_eoi,
  input  logic [BASE_W-1:0]  vec_base,
  input  logic               eoi_req,
  input  logic               eoi_specific,
  input  logic [LVL_W-1:0]   eoi_lvl,
  output logic               int_out,
  output logic [VEC_W-1:0]   vec_out,
  output logic               vec_oe,
  output logic [NUM_IRQ-1:0] irr_stat,
  output logic [NUM_IRQ-1:0] isr_stat,
  output logic [NUM_IRQ-1:0] imr_stat
);

  logic [NUM_IRQ-1:0] imr_q;
  logic [NUM_IRQ-1:0] irr_w;
  logic [NUM_IRQ-1:0] isr_w;
  logic               req_any;
  logic [LVL_W-1:0]   req_lvl;
  logic               in_ack;
  logic               clr_en;
  logic [LVL_W-1:0]   clr_idx;
  logic               ev_first;

  always_ff @(posedge clk) begin
    if (!rst_n) imr_q <= '1;
    else        imr_q <= mask_in;
  end

  irq_req_latch #(.N(NUM_IRQ), .LW(LVL_W)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_in     (irq_in),
    .level_mode (level_mode),
    .freeze     (in_ack),
    .clr_en     (clr_en),
    .clr_idx    (clr_idx),
    .irr        (irr_w)
  );

  irq_prio_pick #(.N(NUM_IRQ), .LW(LVL_W)) u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .irr     (irr_w),
    .imr     (imr_q),
    .isr     (isr_w),
    .req_any (req_any),
    .req_lvl (req_lvl)
  );

  irq_ack_seq #(.N(NUM_IRQ), .LW(LVL_W), .VW(VEC_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .ack_n        (ack_n),
    .req_any      (req_any),
    .req_lvl      (req_lvl),
    .auto_eoi     (auto_eoi),
    .eoi_req      (eoi_req),
    .eoi_specific (eoi_specific),
    .eoi_lvl      (eoi_lvl),
    .vec_base     (vec_base),
    .in_ack       (in_ack),
    .clr_en       (clr_en),
    .clr_idx      (clr_idx),
    .ev_first     (ev_first),
    .isr          (isr_w),
    .vec_out      (vec_out),
    .vec_oe       (vec_oe)
  );

  assign int_out  = req_any & ~in_ack;
  assign irr_stat = irr_w;
  assign isr_stat = isr_w;
  assign imr_stat = imr_q;

  AST_INT_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr_w & ~imr_q) != '0)); // R1

  AST_INT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ack && !ack_n && $past(ack_n)) |=> !int_out); // R4

  AST_CLAIM_CLEARS_IRR: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_first && req_any) |=> !irr_w[$past(req_lvl)]); // R4

  AST_IMR_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (imr_q == $past(mask_in))); // R11

endmodule

// File: tb/irq_ack_core_bench.sv
`timescale 1ns/1ps
module irq_ack_core_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       ack_n = 1'b1;
  logic [7:0] mask_in = '0;
  logic       level_mode = 1'b0;
  logic       auto_eoi = 1'b0;
  logic [4:0] vec_base = 5'h03;
  logic       eoi_req = 1'b0;
  logic       eoi_specific = 1'b0;
  logic [2:0] eoi_lvl = '0;
  logic       int_out;
  logic [7:0] vec_out;
  logic       vec_oe;
  logic [7:0] irr_stat, isr_stat, imr_stat;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_ack_core u_irq_ack_core (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack_n(ack_n), .mask_in(mask_in),
    .level_mode(level_mode), .auto_eoi(auto_eoi), .vec_base(vec_base),
    .eoi_req(eoi_req), .eoi_specific(eoi_specific), .eoi_lvl(eoi_lvl),
    .int_out(int_out), .vec_out(vec_out), .vec_oe(vec_oe),
    .irr_stat(irr_stat), .isr_stat(isr_stat), .imr_stat(imr_stat)
  );

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic ack_first();
    ack_n = 1'b0;
    step();
  endtask

  task automatic ack_rest(output logic [7:0] v, output logic oe);
    ack_n = 1'b1;
    step();
    ack_n = 1'b0;
    step();
    v  = vec_out;
    oe = vec_oe;
    ack_n = 1'b1;
    step();
  endtask

  task automatic eoi(input logic spec, input logic [2:0] lvl);
    eoi_req = 1'b1;
    eoi_specific = spec;
    eoi_lvl = lvl;
    step();
    eoi_req = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    mask_in = 8'h00;
    repeat (3) step();
    chk("R10", "irr in reset", irr_stat, 8'h00);
    chk("R10", "isr in reset", isr_stat, 8'h00);
    chk("R10", "imr in reset", imr_stat, 8'hFF);
    chk("R10", "int in reset", {7'b0, int_out}, 8'h00);
    chk("R10", "vec_oe in reset", {7'b0, vec_oe}, 8'h00);
    rst_n = 1'b1;
    step();
    chk("R11", "imr after reset", imr_stat, 8'h00);
  endtask

  task automatic t_basic();
    logic [7:0] v; logic oe;
    irq_in = 8'h08; step();
    chk("R2", "irr edge latch", irr_stat, 8'h08);
    chk("R8", "int raised", {7'b0, int_out}, 8'h01);
    ack_first();
    chk("R4", "isr after first", isr_stat, 8'h08);
    chk("R4", "irr after first", irr_stat, 8'h00);
    chk("R4", "int after first", {7'b0, int_out}, 8'h00);
    chk("R5", "vec_oe between pulses", {7'b0, vec_oe}, 8'h00);
    ack_rest(v, oe);
    chk("R5", "vector level 3", v, 8'h1B);
    chk("R5", "vec_oe in second", {7'b0, oe}, 8'h01);
    chk("R5", "vec_oe after end", {7'b0, vec_oe}, 8'h00);
    chk("R6", "isr kept without auto", isr_stat, 8'h08);
    eoi(1'b0, 3'd0);
    chk("R7", "nonspecific eoi", isr_stat, 8'h00);
    irq_in = 8'h00; step();
  endtask

  task automatic t_mask();
    logic [7:0] v; logic oe;
    mask_in = 8'h04; step();
    chk("R11", "imr follows", imr_stat, 8'h04);
    irq_in = 8'h04; step();
    chk("R1", "masked irr", irr_stat, 8'h04);
    chk("R1", "masked no int", {7'b0, int_out}, 8'h00);
    irq_in = 8'h24; step();
    chk("R1", "lower level passes", {7'b0, int_out}, 8'h01);
    ack_first();
    chk("R1", "claim skips masked", isr_stat, 8'h20);
    chk("R1", "masked stays pending", irr_stat, 8'h04);
    ack_rest(v, oe);
    chk("R5", "vector level 5", v, 8'h1D);
    eoi(1'b1, 3'd5);
    chk("R7", "specific eoi 5", isr_stat, 8'h00);
    mask_in = 8'h00; step();
    chk("R1", "unmasked int", {7'b0, int_out}, 8'h01);
    ack_first();
    ack_rest(v, oe);
    chk("R5", "vector level 2", v, 8'h1A);
    eoi(1'b0, 3'd0);
    irq_in = 8'h00; step();
  endtask

  task automatic t_level();
    logic [7:0] v; logic oe;
    level_mode = 1'b1;
    irq_in = 8'h02; step();
    chk("R2", "level sets", irr_stat, 8'h02);
    irq_in = 8'h00; step();
    chk("R2", "level drops", irr_stat, 8'h00);
    chk("R2", "level no int", {7'b0, int_out}, 8'h00);
    level_mode = 1'b0;
    irq_in = 8'h01; step();
    irq_in = 8'h00; step();
    chk("R2", "edge held after drop", irr_stat, 8'h01);
    ack_first();
    ack_rest(v, oe);
    chk("R5", "vector level 0", v, 8'h18);
    eoi(1'b0, 3'd0);
  endtask

  task automatic t_freeze();
    logic [7:0] v; logic oe;
    irq_in = 8'h10; step();
    ack_first();
    irq_in = 8'h12;
    ack_rest(v, oe);
    chk("R5", "vector level 4", v, 8'h1C);
    step();
    chk("R3", "edge in window dropped", irr_stat, 8'h00);
    chk("R3", "no int from dropped edge", {7'b0, int_out}, 8'h00);
    chk("R6", "isr level 4 held", isr_stat, 8'h10);
    eoi(1'b0, 3'd0);
    irq_in = 8'h00; step();
  endtask

  task automatic t_nest();
    logic [7:0] v; logic oe;
    irq_in = 8'h08; step();
    ack_first(); ack_rest(v, oe);
    irq_in = 8'h28; step();
    chk("R8", "lower pending", irr_stat, 8'h20);
    chk("R8", "lower blocked by service", {7'b0, int_out}, 8'h00);
    irq_in = 8'h2A; step();
    chk("R8", "higher interrupts", {7'b0, int_out}, 8'h01);
    ack_first(); ack_rest(v, oe);
    chk("R5", "vector level 1", v, 8'h19);
    chk("R4", "nested isr", isr_stat, 8'h0A);
    chk("R4", "irr left", irr_stat, 8'h20);
    eoi(1'b0, 3'd0);
    chk("R7", "nonspecific clears most urgent", isr_stat, 8'h08);
    chk("R8", "still blocked", {7'b0, int_out}, 8'h00);
    eoi(1'b1, 3'd3);
    chk("R7", "specific clears 3", isr_stat, 8'h00);
    chk("R8", "lower now interrupts", {7'b0, int_out}, 8'h01);
    ack_first(); ack_rest(v, oe);
    eoi(1'b0, 3'd0);
    irq_in = 8'h00; step();
  endtask

  task automatic t_aeoi();
    logic [7:0] v; logic oe;
    auto_eoi = 1'b1;
    vec_base = 5'h1F;
    irq_in = 8'h40; step();
    ack_first();
    chk("R4", "isr level 6", isr_stat, 8'h40);
    ack_rest(v, oe);
    chk("R5", "vector base 1F level 6", v, 8'hFE);
    chk("R6", "auto clears isr", isr_stat, 8'h00);
    auto_eoi = 1'b0;
    vec_base = 5'h03;
    irq_in = 8'h00; step();
  endtask

  task automatic t_spur();
    logic [7:0] v; logic oe;
    ack_first();
    chk("R9", "spurious no isr", isr_stat, 8'h00);
    ack_rest(v, oe);
    chk("R9", "spurious vector", v, 8'h1F);
    chk("R9", "spurious isr after", isr_stat, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step();
    t_reset();
    t_basic();
    t_mask();
    t_level();
    t_freeze();
    t_nest();
    t_aeoi();
    t_spur();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule